// File: doc/BRIEF.md
# CEC Frame Receiver with Destination Filter

This block listens to a single-wire consumer-electronics control line and turns the pulses it sees into stored message bytes. The line goes through a two-flop synchronizer and a glitch filter. A timer then measures how long each low pulse lasts and how far apart falling edges are. Every duration is counted in time units, and one unit is `TICK_DIV` clock cycles (nominally 50 µs). A start pulse opens a frame. Each following bit is validated against low-time and period windows. Its value is the filtered line level seen at a fixed sample point after the falling edge. Ten bits make one byte slot: eight data bits sent most significant first, then an end-of-message bit, then an acknowledge bit.

The low nibble of the first byte is the destination. It is compared against several logical-address slots, and each slot has its own enable. A matching directed frame is acknowledged: the block holds the line low at the start of every acknowledge bit. Broadcast frames are stored but never acknowledged. A frame that no rule accepts is dropped without trace. A completed frame stays in the buffer, and `frame_done_o` stays high, until the host pulses `release_i`. A reject control drops every frame. A loopback control stores frames for any destination.

Controller states, named in the RTL: IDLE waits for a falling edge and moves to START_LO. START_LO times the start low and moves to START_HI, or back to IDLE if the window is missed. START_HI checks the start period and moves to BIT_LO, or back to IDLE. BIT_LO times a bit low and moves to BIT_HI, or to HOLD on the final acknowledge bit, or to IDLE on an error or a dropped header. BIT_HI checks the bit period and moves to BIT_LO, or to IDLE on an error or a dropped header. HOLD waits for release and then moves to IDLE.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset, the following are all zero: `frame_done_o`, `cec_pull_o`, `rx_count_o`, `err_timing_o` and `err_line_o`.
- R2: A frame opens only on a start pulse with a low time of 70 to 78 units and a fall-to-fall period of 86 to 94 units. Any other pulse is ignored, with no error, no acknowledge and no capture.
- R3: A data bit's value is the filtered line level at 21 units after its falling edge, with 1 meaning high. Bits are assembled most significant first into a byte. The bit's low time must fall in the logic-0 window (26 to 34 units) or the logic-1 window (8 to 16 units).
- R4: A bit low time outside both windows is a timing error. So is a bit period outside 41 to 55 units, which includes a high time running past 55 units. Either one sets `err_timing_o` and abandons the frame.
- R5: A bit low time beyond 57 units sets `err_line_o` and abandons the frame.
- R6: Each entry k holds a byte in `rx_bytes_o[8k+7:8k]` and its end-of-message bit in `rx_eom_o[k]`. `rx_count_o` gives the number of stored entries. The frame ends after the acknowledge bit of the first entry whose end-of-message bit is 1, or after the 16th entry.
- R7: The destination is bits [3:0] of the first byte. It matches when it equals `slot_addr_i[4s+3:4s]` for some slot s with `slot_en_i[s]` = 1. A disabled slot never matches.
- R8: For a matched destination other than 0xF, the block drives `cec_pull_o` high for 30 units from the falling edge of every acknowledge bit in the frame. A frame to 0xF is captured and never acknowledged.
- R9: A frame that is not accepted produces no acknowledge and leaves `rx_count_o`, the entries and `frame_done_o` unchanged.
- R10: A completed frame raises `frame_done_o`, which holds until `release_i` is pulsed. While it is held, incoming frames are ignored and get no acknowledge. `release_i` also clears both error flags.
- R11: While `reject_i` = 1, every frame is dropped, whatever its destination.
- R12: While `loopback_i` = 1, frames for any destination are captured. Only matched directed frames are acknowledged.
- R13: A line disturbance shorter than `GLITCH` clock cycles has no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cec_i | input | 1 | Raw line level, 1 = released |
| cec_pull_o | output | 1 | 1 = hold the line low (acknowledge) |
| slot_addr_i | input | NSLOT*4 | Logical address per slot |
| slot_en_i | input | NSLOT | Enable per slot |
| reject_i | input | 1 | Drop all incoming frames |
| loopback_i | input | 1 | Capture every destination |
| release_i | input | 1 | One-cycle pulse that frees the buffer |
| frame_done_o | output | 1 | A complete frame is held |
| err_timing_o | output | 1 | Sticky bit-timing error |
| err_line_o | output | 1 | Sticky overlong-low error |
| rx_count_o | output | $clog2(DEPTH+1) | Entries stored |
| rx_bytes_o | output | DEPTH*8 | Entry bytes, entry k at [8k+7:8k] |
| rx_eom_o | output | DEPTH | End-of-message bit per entry |

## Verification
A stuck or wrong controller state shows up first on `cec_pull_o`. An acknowledge can appear outside an acknowledge bit, or fail to appear by 20 units into one, so the fault is visible within a single bit time. A bad shift register, bit counter or write pointer shows up one frame later, as wrong entries, a wrong `rx_count_o`, or a missing or spurious `frame_done_o`. Timer or window faults raise an error flag within one bit of the faulty measurement, or fail to raise one.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START_LO,
        S_START_HI,
        S_BIT_LO,
        S_BIT_HI,
        S_HOLD
    } rx_state_e;
endpackage

// File: rtl/cec_line_filter.sv
module cec_line_filter #(
    parameter int GLITCH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int GW = $clog2(GLITCH + 1);

    logic    s1_q, s2_q, lvl_q, lvl_d_q;
    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            lvl_q   <= 1'b1;
            lvl_d_q <= 1'b1;
            cnt_q   <= '0;
        end else begin
            s1_q    <= line_i;
            s2_q    <= s1_q;
            lvl_d_q <= lvl_q;
            if (s2_q == lvl_q) begin
                cnt_q <= '0;
            end else if (cnt_q == GW'(GLITCH - 1)) begin
                lvl_q <= s2_q;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl_o  = lvl_q;
    assign fall_o = lvl_d_q & ~lvl_q;
    assign rise_o = ~lvl_d_q & lvl_q;

    // R13
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(s2_q) == lvl_q));
endmodule

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            div_q <= '0;
        else if (div_q == DW'(TICK_DIV - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == DW'(TICK_DIV - 1));
endmodule

// File: rtl/cec_rx_fsm.sv
module cec_rx_fsm
    import cec_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int NSLOT       = 6,
    parameter int TW          = 8,
    parameter int ST_LO_MIN   = 70,
    parameter int ST_LO_MAX   = 78,
    parameter int ST_PER_MIN  = 86,
    parameter int ST_PER_MAX  = 94,
    parameter int L0_MIN      = 26,
    parameter int L0_MAX      = 34,
    parameter int L1_MIN      = 8,
    parameter int L1_MAX      = 16,
    parameter int BIT_PER_MIN = 41,
    parameter int BIT_PER_MAX = 55,
    parameter int SAMP_AT     = 21,
    parameter int LINE_MAX    = 57,
    parameter int ACK_LEN     = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic                       lvl_i,
    input  logic                       fall_i,
    input  logic                       rise_i,
    input  logic [NSLOT*4-1:0]         slot_addr_i,
    input  logic [NSLOT-1:0]           slot_en_i,
    input  logic                       reject_i,
    input  logic                       loopback_i,
    input  logic                       release_i,
    output logic                       pull_o,
    output logic                       done_o,
    output logic                       err_timing_o,
    output logic                       err_line_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [DEPTH*8-1:0]         bytes_o,
    output logic [DEPTH-1:0]           eom_o
);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);
    localparam logic [TW-1:0] K_SLMIN = TW'(ST_LO_MIN);
    localparam logic [TW-1:0] K_SLMAX = TW'(ST_LO_MAX);
    localparam logic [TW-1:0] K_SPMIN = TW'(ST_PER_MIN);
    localparam logic [TW-1:0] K_SPMAX = TW'(ST_PER_MAX);
    localparam logic [TW-1:0] K_L0MIN = TW'(L0_MIN);
    localparam logic [TW-1:0] K_L0MAX = TW'(L0_MAX);
    localparam logic [TW-1:0] K_L1MIN = TW'(L1_MIN);
    localparam logic [TW-1:0] K_L1MAX = TW'(L1_MAX);
    localparam logic [TW-1:0] K_BPMIN = TW'(BIT_PER_MIN);
    localparam logic [TW-1:0] K_BPMAX = TW'(BIT_PER_MAX);
    localparam logic [TW-1:0] K_SAMP  = TW'(SAMP_AT);
    localparam logic [TW-1:0] K_LINE  = TW'(LINE_MAX);
    localparam logic [TW-1:0] K_ACK   = TW'(ACK_LEN - 1);
    localparam logic [PW-1:0] K_LAST  = PW'(DEPTH - 1);

    rx_state_e       state_q, state_n;
    logic [TW-1:0]   tcnt_q, ack_cnt_q;
    logic [3:0]      idx_q;
    logic [7:0]      sh_q;
    logic [PW-1:0]   ptr_q, cnt_q;
    logic            last_q, ack_en_q, pull_q, done_q, errt_q, errl_q;
    logic [7:0]      mem_q [DEPTH];
    logic [DEPTH-1:0] eom_q;

    logic            in_bit, samp_ev, lowok, per_ok, st_lo_ok, st_per_ok;
    logic            match, accept, hdr_ev, drop_ev, fin_ev, t_err, l_err;
    logic [7:0]      cur_byte;
    logic [NSLOT-1:0] slot_hit;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign slot_hit[g] = slot_en_i[g] && (slot_addr_i[g*4 +: 4] == cur_byte[3:0]);
    end
    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign bytes_o[g*8 +: 8] = mem_q[g];
    end

    assign in_bit    = (state_q == S_BIT_LO) || (state_q == S_BIT_HI);
    assign samp_ev   = in_bit && tick_i && (tcnt_q == K_SAMP);
    assign cur_byte  = {sh_q[6:0], lvl_i};
    assign match     = |slot_hit;
    assign accept    = !reject_i && (loopback_i || match || cur_byte[3:0] == 4'hF);
    assign hdr_ev    = samp_ev && (idx_q == 4'd7) && (ptr_q == '0);
    assign drop_ev   = hdr_ev && !accept;
    assign lowok     = (tcnt_q >= K_L0MIN && tcnt_q <= K_L0MAX) ||
                       (tcnt_q >= K_L1MIN && tcnt_q <= K_L1MAX);
    assign per_ok    = (tcnt_q >= K_BPMIN) && (tcnt_q <= K_BPMAX);
    assign st_lo_ok  = (tcnt_q >= K_SLMIN) && (tcnt_q <= K_SLMAX);
    assign st_per_ok = (tcnt_q >= K_SPMIN) && (tcnt_q <= K_SPMAX);
    assign l_err     = (state_q == S_BIT_LO) && (tcnt_q > K_LINE);
    assign t_err     = ((state_q == S_BIT_LO) && !l_err && rise_i && !lowok) ||
                       ((state_q == S_BIT_HI) && ((fall_i && !per_ok) || tcnt_q > K_BPMAX));
    assign fin_ev    = (state_q == S_BIT_LO) && !l_err && rise_i && lowok &&
                       (idx_q == 4'd9) && last_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:     if (fall_i) state_n = S_START_LO;
            S_START_LO: if (rise_i) state_n = st_lo_ok ? S_START_HI : S_IDLE;
                        else if (tcnt_q > K_SLMAX) state_n = S_IDLE;
            S_START_HI: if (fall_i) state_n = st_per_ok ? S_BIT_LO : S_IDLE;
                        else if (tcnt_q > K_SPMAX) state_n = S_IDLE;
            S_BIT_LO:   if (l_err || t_err || drop_ev) state_n = S_IDLE;
                        else if (fin_ev) state_n = S_HOLD;
                        else if (rise_i) state_n = S_BIT_HI;
            S_BIT_HI:   if (t_err || drop_ev) state_n = S_IDLE;
                        else if (fall_i) state_n = S_BIT_LO;
            S_HOLD:     if (release_i) state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0; ack_cnt_q <= '0; idx_q <= '0; sh_q <= '0;
            ptr_q <= '0; cnt_q <= '0; last_q <= 1'b0; ack_en_q <= 1'b0;
            pull_q <= 1'b0; done_q <= 1'b0; errt_q <= 1'b0; errl_q <= 1'b0;
            eom_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (fall_i)                            tcnt_q <= '0;
            else if (tick_i && tcnt_q != '1)       tcnt_q <= tcnt_q + 1'b1;

            if (state_q == S_START_HI && state_n == S_BIT_LO) begin
                idx_q <= '0; ptr_q <= '0; last_q <= 1'b0; ack_en_q <= 1'b0;
            end else if (state_q == S_BIT_HI && state_n == S_BIT_LO) begin
                idx_q <= (idx_q == 4'd9) ? 4'd0 : idx_q + 1'b1;
            end

            if (samp_ev && idx_q < 4'd8) sh_q <= cur_byte;
            if (hdr_ev) ack_en_q <= match && (cur_byte[3:0] != 4'hF);

            if (samp_ev && idx_q == 4'd8 && state_n != S_IDLE) begin
                mem_q[ptr_q[AW-1:0]] <= sh_q;
                eom_q[ptr_q[AW-1:0]] <= lvl_i;
                ptr_q  <= ptr_q + 1'b1;
                cnt_q  <= ptr_q + 1'b1;
                last_q <= lvl_i || (ptr_q == K_LAST);
            end

            if (state_n == S_IDLE) begin
                pull_q <= 1'b0;
            end else if (state_q == S_BIT_HI && state_n == S_BIT_LO &&
                         idx_q == 4'd8 && ack_en_q) begin
                pull_q    <= 1'b1;
                ack_cnt_q <= '0;
            end else if (pull_q && tick_i) begin
                if (ack_cnt_q == K_ACK) pull_q <= 1'b0;
                ack_cnt_q <= ack_cnt_q + 1'b1;
            end

            if (state_n == S_HOLD && state_q != S_HOLD) done_q <= 1'b1;
            else if (state_q == S_HOLD && release_i)    done_q <= 1'b0;

            if (release_i) begin
                errt_q <= 1'b0;
                errl_q <= 1'b0;
            end
            if (t_err) errt_q <= 1'b1;
            if (l_err) errl_q <= 1'b1;
        end
    end

    assign pull_o       = pull_q;
    assign done_o       = done_q;
    assign err_timing_o = errt_q;
    assign err_line_o   = errl_q;
    assign count_o      = cnt_q;
    assign eom_o        = eom_q;

    // R10
    hold_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |-> !pull_q);
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !release_i) |=> done_q);
    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PW'(DEPTH));
    // R8
    ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_q) |-> (state_q == S_BIT_LO && idx_q == 4'd9));
    // R5
    line_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(errl_q) |-> ($past(state_q) == S_BIT_LO));
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx #(
    parameter int TICK_DIV = 2,
    parameter int GLITCH   = 3,
    parameter int DEPTH    = 16,
    parameter int NSLOT    = 6,
    parameter int TW       = 8,
    parameter int ACK_LEN  = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cec_i,
    output logic                       cec_pull_o,
    input  logic [NSLOT*4-1:0]         slot_addr_i,
    input  logic [NSLOT-1:0]           slot_en_i,
    input  logic                       reject_i,
    input  logic                       loopback_i,
    input  logic                       release_i,
    output logic                       frame_done_o,
    output logic                       err_timing_o,
    output logic                       err_line_o,
    output logic [$clog2(DEPTH+1)-1:0] rx_count_o,
    output logic [DEPTH*8-1:0]         rx_bytes_o,
    output logic [DEPTH-1:0]           rx_eom_o
);
    logic tick, lvl, fall, rise;

    cec_line_filter #(.GLITCH(GLITCH)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_i(cec_i),
        .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
    );

    cec_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    cec_rx_fsm #(.DEPTH(DEPTH), .NSLOT(NSLOT), .TW(TW), .ACK_LEN(ACK_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .lvl_i(lvl),
        .fall_i(fall), .rise_i(rise),
        .slot_addr_i(slot_addr_i), .slot_en_i(slot_en_i),
        .reject_i(reject_i), .loopback_i(loopback_i), .release_i(release_i),
        .pull_o(cec_pull_o), .done_o(frame_done_o),
        .err_timing_o(err_timing_o), .err_line_o(err_line_o),
        .count_o(rx_count_o), .bytes_o(rx_bytes_o), .eom_o(rx_eom_o)
    );
endmodule

// File: tb/cec_frame_rx_tb.sv
module cec_frame_rx_tb;
    localparam int TD = 2;
    localparam int NS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blow = 1'b0;
    logic        cec_line;
    logic        cec_pull;
    logic [NS*4-1:0] slot_addr = {4'hB, 4'h0, 4'h0, 4'h0, 4'h9, 4'h4};
    logic [NS-1:0]   slot_en   = 6'b100001;
    logic        rej = 1'b0, loopb = 1'b0, rel = 1'b0;
    logic        done, et, el;
    logic [4:0]  cnt;
    logic [127:0] bytes;
    logic [15:0] eoms;

    int compared = 0, mism = 0;
    logic pull_dc = 1'b1;
    logic finished = 1'b0;

    logic [7:0] fb [16];
    logic       fe [16];
    int         fn;
    logic [7:0] m_b [16];
    logic       m_e [16];
    int         m_cnt = 0;
    logic       m_done = 1'b0, m_et = 1'b0, m_el = 1'b0;

    always #2 clk = ~clk;
    assign cec_line = ~(blow | cec_pull);

    cec_frame_rx #(.TICK_DIV(TD), .NSLOT(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cec_i(cec_line), .cec_pull_o(cec_pull),
        .slot_addr_i(slot_addr), .slot_en_i(slot_en),
        .reject_i(rej), .loopback_i(loopb), .release_i(rel),
        .frame_done_o(done), .err_timing_o(et), .err_line_o(el),
        .rx_count_o(cnt), .rx_bytes_o(bytes), .rx_eom_o(eoms)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mism++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R8: outside acknowledge bits the pull must stay released
    always @(negedge clk) begin
        if (rst_n && !pull_dc && !finished) begin
            compared++;
            if (cec_pull !== 1'b0) begin
                mism++;
                $display("FAIL R8 stray pull actual=%0b expected=0", cec_pull);
            end
        end
    end

    task automatic wclk(int n); repeat (n) @(negedge clk); endtask
    task automatic wu(int n); wclk(n * TD); endtask
    task automatic pulse(int lo, int per);
        blow = 1'b1; wu(lo); blow = 1'b0; wu(per - lo);
    endtask
    task automatic send_data(logic b, logic glitch);
        if (glitch && b) begin
            blow = 1'b1; wu(12); blow = 1'b0; wu(10);
            blow = 1'b1; wclk(1); blow = 1'b0;
            wclk(48 * TD - 22 * TD - 1);
        end else begin
            pulse(b ? 12 : 30, 48);
        end
    endtask
    task automatic send_ack(logic exp);
        pull_dc = 1'b1;
        blow = 1'b1; wu(12); blow = 1'b0; wu(8);
        chk("R8 ack level", cec_pull, exp);
        wu(22); pull_dc = 1'b0; wu(6);
    endtask
    task automatic send_bytes(logic exp, int gk);
        for (int k = 0; k < fn; k++) begin
            for (int b = 7; b >= 0; b--) send_data(fb[k][b], k == gk);
            send_data(fe[k], 1'b0);
            send_ack(exp);
        end
    endtask

    function automatic logic f_match(logic [3:0] d);
        logic m = 1'b0;
        for (int s = 0; s < NS; s++)
            if (slot_en[s] && slot_addr[s*4 +: 4] == d) m = 1'b1;
        return m;
    endfunction

    // behavioural model: computes ack, then updates the expected buffer
    task automatic frame(int gk);
        logic [3:0] d = fb[0][3:0];
        logic ack = !m_done && !rej && f_match(d) && d != 4'hF;
        logic acc = !m_done && !rej && (loopb || f_match(d) || d == 4'hF);
        pulse(74, 90);
        send_bytes(ack, gk);
        if (acc) begin
            for (int k = 0; k < fn; k++) begin m_b[k] = fb[k]; m_e[k] = fe[k]; end
            m_cnt = fn; m_done = 1'b1;
        end
        wu(20);
    endtask

    task automatic check_all(string req);
        chk({req, " done"}, done, m_done);
        chk({req, " count"}, cnt, m_cnt);
        chk({req, " err_timing"}, et, m_et);
        chk({req, " err_line"}, el, m_el);
        for (int k = 0; k < m_cnt; k++) begin
            chk({req, " R3 byte"}, bytes[k*8 +: 8], m_b[k]);
            chk({req, " R6 eom"}, eoms[k], m_e[k]);
        end
    endtask

    task automatic release_buf();
        rel = 1'b1; wclk(1); rel = 1'b0; wclk(2);
        m_done = 1'b0; m_et = 1'b0; m_el = 1'b0;
    endtask

    task automatic set2(logic [7:0] a, logic [7:0] b);
        fn = 2; fb[0] = a; fe[0] = 1'b0; fb[1] = b; fe[1] = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        mism++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        wclk(5); rst_n = 1'b1; wclk(4);
        // R1 reset state
        chk("R1 pull", cec_pull, 0);
        check_all("R1");
        pull_dc = 1'b0;

        // R7/R8 directed frame to slot 0, three entries
        fn = 3; fb[0] = 8'h34; fe[0] = 0; fb[1] = 8'hA5; fe[1] = 0; fb[2] = 8'h0F; fe[2] = 1;
        frame(-1); check_all("R7");
        // R10 frame while held is ignored
        set2(8'h34, 8'h11); frame(-1); check_all("R10 held");
        release_buf(); check_all("R10 release");
        // R9 non-matching destination
        set2(8'h37, 8'h22); frame(-1); check_all("R9 nomatch");
        // R7 disabled slot
        set2(8'h39, 8'h23); frame(-1); check_all("R7 disabled slot");
        // R8 broadcast captured, not acknowledged
        set2(8'h3F, 8'h44); frame(-1); check_all("R8 broadcast"); release_buf();
        // R7 last slot
        set2(8'h1B, 8'h55); frame(-1); check_all("R7 slot5"); release_buf();
        // R11 reject
        rej = 1'b1; set2(8'h34, 8'h66); frame(-1); check_all("R11"); rej = 1'b0;
        // R12 loopback
        loopb = 1'b1; set2(8'h37, 8'h77); frame(-1); check_all("R12"); loopb = 1'b0;
        release_buf();
        // R6 full buffer without end-of-message
        fn = 16;
        for (int k = 0; k < 16; k++) begin fb[k] = (k == 0) ? 8'h34 : 8'(k * 13); fe[k] = 1'b0; end
        frame(-1); check_all("R6 full"); release_buf();
        // R2 bad start low, then a valid-looking body: nothing happens
        set2(8'h34, 8'h88); pulse(60, 90); send_bytes(1'b0, -1); wu(20);
        check_all("R2 bad start");
        // R4 low time between windows
        pulse(74, 90); send_data(0, 0); send_data(0, 0); send_data(1, 0);
        pulse(22, 48); wu(80); m_et = 1'b1; check_all("R4 bad low");
        release_buf(); check_all("R10 clear err");
        // R4 period overrun (line stays high)
        pulse(74, 90); send_data(0, 0); send_data(1, 0); send_data(1, 0);
        wu(80); m_et = 1'b1; check_all("R4 period"); release_buf();
        // R5 overlong low
        pulse(74, 90); send_data(0, 0); pulse(65, 80); wu(40);
        m_el = 1'b1; check_all("R5 line"); release_buf(); check_all("R5 cleared");
        // R13 short glitch inside the second byte
        set2(8'h34, 8'hFF); frame(1); check_all("R13 glitch"); release_buf();
        wu(10);
        finish_run();
    end
endmodule